// File: doc/BRIEF.md
# Serial Byte Memory Slave with Write Gating

This block is the serial-bus front end of a small byte-wide nonvolatile memory. It works in SPI mode 0 with the most significant bit first. An 8-bit command comes first, then one address byte, then data bytes. The block shifts read data out, and it commits a single write byte into a local byte array that stands in for the storage cells. All serial pins are brought into the system clock domain through a synchronizer. Edges of the serial clock and of the chip select are then detected on system clock cycles.

Two rules gate writes into the array. First, the slave does not respond to anything until it has seen a real chip-select falling edge after reset. Second, the active-low write-protect input vetoes a write if it is low at any time while the frame is open. Once the write has committed at the chip-select rising edge, a modelled busy interval of fixed length starts, and write protect no longer has any effect. While busy, only the status command is served.

Top module: `spi_mem_slave`

## Requirements
- R1: The bit on `si` is taken on each rising edge of `sck` and bytes are assembled most significant bit first. Command codes: 0x03 reads, 0x02 writes, 0x05 reads status.
- R2: During a read, `so` changes only after a falling edge of `sck`. It holds its value for the whole high phase of `sck`.
- R3: `so_oe` is 0 while the slave is deselected: after reset, and after every rising edge of `cs_n`. It is 1 during an accepted frame.
- R4: After reset the slave ignores every bit until a high-to-low transition of `cs_n`. A frame already open when reset is released neither writes nor drives `so`.
- R5: A write frame that ends while `wp_n` is low leaves the array unchanged and starts no busy interval.
- R6: A low pulse on `wp_n` at any point inside a write frame cancels the write, even if `wp_n` is high again when `cs_n` rises.
- R7: A change of `wp_n` after the write has committed, at the `cs_n` rising edge, does not affect the stored byte.
- R8: A committed write sets busy for exactly BUSY_CYC system clocks. Status command 0x05 returns a byte whose bit 0 is busy and whose other bits are 0.
- R9: While busy, any command other than 0x05 is ignored. A read shifts out 0x00 and a write stores nothing.
- R10: A read returns the byte at the given address, then the following addresses in order. The address wraps from the last byte to address 0. The address uses the low ADDR_W bits of the address byte.
- R11: A write commits only when `cs_n` rises on a byte boundary after at least one full data byte. A frame cut off inside a byte, or one with no data byte, writes nothing.
- R12: An unknown command byte is ignored and `so` stays 0 for the rest of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock (mode 0) |
| si | input | 1 | Serial data into the slave |
| cs_n | input | 1 | Active-low chip select |
| wp_n | input | 1 | Active-low write protect |
| so | output | 1 | Serial data out of the slave |
| so_oe | output | 1 | Output enable for `so` (tri-state control) |

## Verification
Some properties are checked by assertions on every cycle. The output shift register moves only on a serial-clock falling edge or at a frame end. The output enable drops after each chip-select rise. Arming stays set once set. A write pulse only comes at a chip-select rise, with write protect high and the array idle, and it always raises busy. The effects on stored data can only be shown by the bench scenarios: a full write-then-read sweep over every address, the wrap of a burst read, write-protect pulses before and after commit, truncated frames, busy-time rejection of commands, and a frame left open across reset.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_WRITE = 8'h02;
    localparam logic [7:0] OPC_STAT  = 8'h05;

    typedef enum logic [1:0] {
        PH_OPC,
        PH_ADDR,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_READ,
        CMD_WRITE,
        CMD_STAT
    } cmd_e;

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic si,
    input  logic cs_n,
    input  logic wp_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic si_s,
    output logic wp_s
);

    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] si;
        logic [STAGES-1:0] csn;
        logic [STAGES-1:0] wp;
        logic              sck_prev;
        logic              csn_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d = q;
        d.sck      = {q.sck[STAGES-2:0], sck};
        d.si       = {q.si[STAGES-2:0], si};
        d.csn      = {q.csn[STAGES-2:0], cs_n};
        d.wp       = {q.wp[STAGES-2:0], wp_n};
        d.sck_prev = q.sck[TOP];
        d.csn_prev = q.csn[TOP];
    end

    // chip select resets to "low" so a frame open at reset yields no fall
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sck_rise = q.sck[TOP] & ~q.sck_prev;
    assign sck_fall = ~q.sck[TOP] & q.sck_prev;
    assign cs_fall  = ~q.csn[TOP] & q.csn_prev;
    assign cs_rise  = q.csn[TOP] & ~q.csn_prev;
    assign si_s     = q.si[TOP];
    assign wp_s     = q.wp[TOP];

endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
    parameter int ADDR_W   = 4,
    parameter int BUSY_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [CNT_W-1:0]      cnt;
    } arr_t;

    arr_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            d.mem[wr_addr] = wr_data;
            d.cnt          = CNT_W'(BUSY_CYC);
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_data = q.mem[rd_addr];
    assign busy    = (q.cnt != '0);

    AST_WR_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !busy); // R9
    AST_WR_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> busy); // R8

endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              si_s,
    input  logic              wp_s,
    input  logic              busy,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_start,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              so_bit,
    output logic              active
);

    typedef struct packed {
        logic              armed;
        logic              active;
        phase_e            phase;
        cmd_e              cmd;
        logic [2:0]        bitcnt;
        logic [7:0]        sreg;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdata;
        logic              wvalid;
        logic              cancel;
        logic [7:0]        tx;
    } ctrl_t;

    ctrl_t q, d;
    logic [7:0] byte_in;

    always_comb begin
        d        = q;
        wr_start = 1'b0;
        byte_in  = {q.sreg[6:0], si_s};
        if (cs_fall) begin
            d.armed  = 1'b1;
            d.active = 1'b1;
            d.phase  = PH_OPC;
            d.cmd    = CMD_NONE;
            d.bitcnt = '0;
            d.wvalid = 1'b0;
            d.cancel = 1'b0;
            d.tx     = '0;
        end else if (cs_rise) begin
            if (q.active && q.cmd == CMD_WRITE && q.wvalid && !q.cancel
                && wp_s && q.bitcnt == '0 && !busy) begin
                wr_start = 1'b1;
            end
            d.active = 1'b0;
            d.phase  = PH_OPC;
            d.tx     = '0;
        end else if (q.active) begin
            if (!wp_s) begin
                d.cancel = 1'b1;
            end
            if (sck_rise) begin
                d.sreg   = byte_in;
                d.bitcnt = q.bitcnt + 3'd1;
                if (q.bitcnt == 3'd7) begin
                    unique case (q.phase)
                        PH_OPC: begin
                            if (busy && byte_in != OPC_STAT) begin
                                d.phase = PH_SKIP;
                            end else if (byte_in == OPC_READ) begin
                                d.cmd   = CMD_READ;
                                d.phase = PH_ADDR;
                            end else if (byte_in == OPC_WRITE) begin
                                d.cmd   = CMD_WRITE;
                                d.phase = PH_ADDR;
                            end else if (byte_in == OPC_STAT) begin
                                d.cmd   = CMD_STAT;
                                d.phase = PH_DATA;
                            end else begin
                                d.phase = PH_SKIP;
                            end
                        end
                        PH_ADDR: begin
                            d.addr  = byte_in[ADDR_W-1:0];
                            d.phase = PH_DATA;
                        end
                        PH_DATA: begin
                            if (q.cmd == CMD_WRITE) begin
                                d.wdata  = byte_in;
                                d.wvalid = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            if (sck_fall) begin
                if (q.phase == PH_DATA && q.bitcnt == '0 && q.cmd == CMD_READ) begin
                    d.tx   = rd_data;
                    d.addr = q.addr + ADDR_W'(1);
                end else if (q.phase == PH_DATA && q.bitcnt == '0 && q.cmd == CMD_STAT) begin
                    d.tx = {7'b0, busy};
                end else begin
                    d.tx = {q.tx[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_addr = q.addr;
    assign wr_addr = q.addr;
    assign wr_data = q.wdata;
    assign so_bit  = q.tx[7];
    assign active  = q.active;

    AST_TX_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall && !cs_rise && !cs_fall) |=> $stable(q.tx)); // R2
    AST_ARMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        q.armed |=> q.armed); // R4
    AST_NO_WR_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> q.armed); // R4

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
    parameter int ADDR_W      = 4,
    parameter int BUSY_CYC    = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic si,
    input  logic cs_n,
    input  logic wp_n,
    output logic so,
    output logic so_oe
);

    logic              sck_rise, sck_fall, cs_fall, cs_rise, si_s, wp_s;
    logic              busy, wr_start, so_bit, active;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [7:0]        rd_data, wr_data;

    spi_mem_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .si       (si),
        .cs_n     (cs_n),
        .wp_n     (wp_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .si_s     (si_s),
        .wp_s     (wp_s)
    );

    spi_mem_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .si_s     (si_s),
        .wp_s     (wp_s),
        .busy     (busy),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_start (wr_start),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .so_bit   (so_bit),
        .active   (active)
    );

    spi_mem_array #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)) array_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_start),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .busy    (busy)
    );

    assign so_oe = active;
    assign so    = active & so_bit;

    AST_SO_HIZ_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !so_oe); // R3
    AST_WR_NEEDS_WP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> wp_s); // R5
    AST_WR_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> cs_rise); // R11

endmodule

// File: tb/spi_mem_slave_tb_top.sv
module spi_mem_slave_tb_top;

    localparam int ADDR_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int IDLE_WAIT = 2300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic cs_n = 1'b0;
    logic wp_n = 1'b1;
    logic so, so_oe;

    int checks = 0;
    int errors = 0;
    int hold_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spi_mem_slave dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .sck   (sck),
        .si    (si),
        .cs_n  (cs_n),
        .wp_n  (wp_n),
        .so    (so),
        .so_oe (so_oe)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 5) & 8'hFF);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            si = tx[i];
            repeat (8) @(negedge clk);
            rx[i] = so;
            sck = 1'b1;
            repeat (7) @(negedge clk);
            if (so !== rx[i]) hold_err++;
            @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_bits(tx, 8, rx);
    endtask

    task automatic frame_begin;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (16) @(negedge clk);
    endtask

    task automatic frame_end;
        repeat (8) @(negedge clk);
        cs_n = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    task automatic do_write(input int a, input logic [7:0] v);
        logic [7:0] r;
        frame_begin;
        xfer(8'h02, r);
        xfer(8'(a), r);
        xfer(v, r);
        frame_end;
    endtask

    task automatic do_read(input int a, output logic [7:0] v);
        logic [7:0] r;
        frame_begin;
        xfer(8'h03, r);
        xfer(8'(a), r);
        xfer(8'h00, v);
        frame_end;
    endtask

    task automatic do_status(output logic [7:0] v);
        logic [7:0] r;
        frame_begin;
        xfer(8'h05, r);
        xfer(8'h00, v);
        frame_end;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, v;
        logic [7:0] model [DEPTH];
        for (int a = 0; a < DEPTH; a++) model[a] = 8'h00;

        // R4: frame already open while reset releases
        repeat (20) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R3 reset so_oe", {7'b0, so_oe}, 8'h00);
        xfer(8'h02, r);
        xfer(8'h03, r);
        check("R4 so_oe while unarmed", {7'b0, so_oe}, 8'h00);
        xfer(8'h5A, r);
        frame_end;
        repeat (IDLE_WAIT) @(negedge clk);
        do_read(3, v);
        check("R4 no write before arming", v, 8'h00);

        do_status(v);
        check("R8 idle status", v, 8'h00);

        // R1: sweep every address
        for (int a = 0; a < DEPTH; a++) begin
            do_write(a, pat(a));
            model[a] = pat(a);
            repeat (IDLE_WAIT) @(negedge clk);
        end

        // R10: burst with wrap, R3 enable during frame
        hold_err = 0;
        frame_begin;
        xfer(8'h03, r);
        xfer(8'h00, r);
        for (int k = 0; k <= DEPTH; k++) begin
            xfer(8'h00, v);
            check("R1 R10 burst read", v, model[k % DEPTH]);
        end
        check("R3 so_oe in frame", {7'b0, so_oe}, 8'h01);
        frame_end;
        check("R3 so_oe after frame", {7'b0, so_oe}, 8'h00);
        check("R2 so stable while sck high", 8'(hold_err), 8'h00);

        frame_begin;
        xfer(8'h03, r);
        xfer(8'(DEPTH - 2), r);
        for (int k = 0; k < 3; k++) begin
            xfer(8'h00, v);
            check("R10 wrap read", v, model[(DEPTH - 2 + k) % DEPTH]);
        end
        frame_end;

        // R8 / R9: busy window
        do_write(5, 8'hC3);
        do_status(v);
        check("R8 busy status", v, 8'h01);
        do_read(5, v);
        check("R9 read ignored while busy", v, 8'h00);
        do_write(6, 8'h11);
        repeat (IDLE_WAIT) @(negedge clk);
        model[5] = 8'hC3;
        do_status(v);
        check("R8 busy cleared", v, 8'h00);
        do_read(5, v);
        check("R8 committed byte", v, model[5]);
        do_read(6, v);
        check("R9 write ignored while busy", v, model[6]);

        // R5: protect held low
        wp_n = 1'b0;
        do_write(7, 8'h77);
        wp_n = 1'b1;
        do_status(v);
        check("R5 no busy when protected", v, 8'h00);
        do_read(7, v);
        check("R5 protected write", v, model[7]);

        // R6: short protect pulse inside frame
        frame_begin;
        xfer(8'h02, r);
        wp_n = 1'b0;
        repeat (16) @(negedge clk);
        wp_n = 1'b1;
        xfer(8'h08, r);
        xfer(8'h88, r);
        frame_end;
        do_read(8, v);
        check("R6 pulse cancels write", v, model[8]);

        // R7: protect dropped after commit
        do_write(9, 8'h99);
        wp_n = 1'b0;
        repeat (IDLE_WAIT) @(negedge clk);
        wp_n = 1'b1;
        model[9] = 8'h99;
        do_read(9, v);
        check("R7 committed write survives", v, model[9]);

        // R11: truncated frames
        frame_begin;
        xfer(8'h02, r);
        xfer(8'h0A, r);
        xfer_bits(8'hAB, 4, r);
        frame_end;
        repeat (IDLE_WAIT) @(negedge clk);
        do_read(10, v);
        check("R11 partial byte", v, model[10]);
        frame_begin;
        xfer(8'h02, r);
        xfer(8'h0B, r);
        frame_end;
        repeat (IDLE_WAIT) @(negedge clk);
        do_read(11, v);
        check("R11 no data byte", v, model[11]);

        // R12: unknown command
        frame_begin;
        xfer(8'hFF, r);
        xfer(8'h00, v);
        xfer(8'h00, r);
        frame_end;
        check("R12 unknown cmd so", v | r, 8'h00);
        do_read(12, v);
        check("R12 memory intact", v, model[12]);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule